// File: doc/BRIEF.md
# Two-Segment CAN Repeater Logic Core

This block is the digital heart of a two-segment CAN transceiver. It sits between a protocol controller and the bus drivers and comparators of two bus segments. Any dominant level, whether it comes from the local controller, from an expansion link to a neighbouring core, or from either segment, is forwarded to every enabled segment and to the receive outputs. Seen from the nodes, the two segments behave as one logical bus. Each segment can be switched off by its own active-low enable. A disabled segment's driver stays recessive and its comparator is ignored.

Forwarding in both directions with no priority would leave the two segments holding each other dominant for ever. To prevent this, the core masks reception on any segment it is driving dominant. When the drive ends, the mask is held for a further release window, measured in clock cycles, so that the segment's own echo can settle first. Comparator outputs pass through a synchronizer before any logic uses them. All outputs are registered.

Top module: `rep_logic_unit`

## Requirements
- R1: At the transmit, comparator and receive pins a low level means dominant and a high level means recessive. A high bit of `drv_dom_o` requests a dominant drive. A segment is enabled when its `bus_en_ni` bit is low.
- R2: A disabled segment never has its `drv_dom_o` bit set, and a dominant level on its comparator input changes no output.
- R3: A low level on `tx_loc_i` or `tx_exp_i` sets `drv_dom_o` for every enabled segment one clock later.
- R4: A dominant comparator level on an enabled, unmasked segment sets `drv_dom_o` of every other enabled segment, and drives both `rx_loc_o` and `rx_exp_o` low. Both take effect three clocks after the comparator changes: two synchronizer stages plus the output register.
- R5: A low level on `tx_loc_i` drives both `rx_loc_o` and `rx_exp_o` low one clock later, whatever the enables are.
- R6: A low level on `tx_exp_i` drives `rx_loc_o` low one clock later and by itself leaves `rx_exp_o` high.
- R7: While a segment's `drv_dom_o` bit is high, a dominant level on that segment's comparator is ignored.
- R8: After a segment's `drv_dom_o` bit falls, its comparator stays masked for the next RELEASE_CYC clock edges. It is honoured again from the edge after that.
- R9: During reset and right after it, `drv_dom_o` is all zero and both receive outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_loc_i | input | 1 | Transmit data from the local controller, low = dominant |
| tx_exp_i | input | 1 | Transmit data from the expansion link, low = dominant |
| bus_en_ni | input | NSEG | Per-segment enable, low = enabled |
| rx_cmp_i | input | NSEG | Per-segment comparator output, low = dominant, asynchronous |
| drv_dom_o | output | NSEG | Per-segment request to drive dominant, high = drive |
| rx_loc_o | output | 1 | Receive data to the local controller, low = dominant |
| rx_exp_o | output | 1 | Receive data to the expansion link, low = dominant |

## Verification
The bench goes after the echo path. Segment 0 is made dominant and the bench then plays segment 1's own echo back on its comparator. A core without the mask, or one that clears it too early, would latch into a permanent dominant state in which both segments drive each other. The bench also holds segment 1's comparator low well past the release window. A mask that never clears would then fail to forward a genuine dominant. Further cases hit the asymmetric receive path, where expansion transmit must not reach `rx_exp_o`, and disabled segments, whose comparator must not leak into the receive outputs. A wrong gate on either would put a false dominant on the controller side.

// File: rtl/rep_pkg.sv
package rep_pkg;
  localparam logic LVL_DOM = 1'b0;
  localparam logic LVL_REC = 1'b1;

  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/rep_sync.sv
module rep_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '1;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '1;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/rep_fbs.sv
module rep_fbs #(
  parameter int unsigned RELEASE_CYC = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic drv_i,
  output logic mask_o
);
  localparam int unsigned CW = rep_pkg::cnt_bits(RELEASE_CYC);

  logic [CW-1:0] hold_q;

  // reload while driving, count down once the drive has ended
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              hold_q <= '0;
    else if (drv_i)           hold_q <= CW'(RELEASE_CYC);
    else if (hold_q != '0)    hold_q <= hold_q - 1'b1;
  end

  assign mask_o = drv_i | (hold_q != '0);

  assert_hold_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q <= CW'(RELEASE_CYC));

  if (RELEASE_CYC > 0) begin : g_hold_chk
    assert_mask_after_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(drv_i) |-> mask_o);
  end
endmodule

// File: rtl/rep_core.sv
module rep_core
  import rep_pkg::*;
#(
  parameter int unsigned NSEG = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tx_loc_i,
  input  logic            tx_exp_i,
  input  logic [NSEG-1:0] en_ni,
  input  logic [NSEG-1:0] rx_sync_i,
  input  logic [NSEG-1:0] mask_i,
  output logic [NSEG-1:0] drv_o,
  output logic            rx_loc_o,
  output logic            rx_exp_o
);
  logic [NSEG-1:0] seg_en, rx_dom, drv_d;
  logic            tx_dom, loc_dom, any_rx;
  logic            rx_loc_d, rx_exp_d;

  assign seg_en  = ~en_ni;
  assign rx_dom  = seg_en & ~rx_sync_i & ~mask_i;
  assign loc_dom = (tx_loc_i == LVL_DOM);
  assign tx_dom  = loc_dom | (tx_exp_i == LVL_DOM);
  assign any_rx  = |rx_dom;

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    logic [NSEG-1:0] others;
    assign others   = rx_dom & ~(NSEG'(1) << k);
    assign drv_d[k] = seg_en[k] & (tx_dom | (|others));

    assert_off_when_disabled_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_ni[k] |=> !drv_o[k]);
    assert_tx_reaches_bus_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_ni[k] && !tx_loc_i) |=> drv_o[k]);
  end

  assign rx_loc_d = ~(tx_dom | any_rx);
  assign rx_exp_d = ~(loc_dom | any_rx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drv_o    <= '0;
      rx_loc_o <= LVL_REC;
      rx_exp_o <= LVL_REC;
    end else begin
      drv_o    <= drv_d;
      rx_loc_o <= rx_loc_d;
      rx_exp_o <= rx_exp_d;
    end
  end

  assert_loc_echo_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_loc_i |=> (!rx_loc_o && !rx_exp_o));
  assert_exp_to_loc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_exp_i |=> !rx_loc_o);
  assert_masked_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_loc_i && tx_exp_i && (&(mask_i | en_ni))) |=> (rx_loc_o && rx_exp_o && drv_o == '0));
endmodule

// File: rtl/rep_logic_unit.sv
module rep_logic_unit #(
  parameter int unsigned NSEG        = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RELEASE_CYC = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tx_loc_i,
  input  logic            tx_exp_i,
  input  logic [NSEG-1:0] bus_en_ni,
  input  logic [NSEG-1:0] rx_cmp_i,
  output logic [NSEG-1:0] drv_dom_o,
  output logic            rx_loc_o,
  output logic            rx_exp_o
);
  logic [NSEG-1:0] rx_sync, seg_mask;

  rep_sync #(.WIDTH(NSEG), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rx_cmp_i),
    .q_o    (rx_sync)
  );

  for (genvar k = 0; k < NSEG; k++) begin : g_fbs
    rep_fbs #(.RELEASE_CYC(RELEASE_CYC)) u_fbs (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .drv_i  (drv_dom_o[k]),
      .mask_o (seg_mask[k])
    );
  end

  rep_core #(.NSEG(NSEG)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_loc_i  (tx_loc_i),
    .tx_exp_i  (tx_exp_i),
    .en_ni     (bus_en_ni),
    .rx_sync_i (rx_sync),
    .mask_i    (seg_mask),
    .drv_o     (drv_dom_o),
    .rx_loc_o  (rx_loc_o),
    .rx_exp_o  (rx_exp_o)
  );

  assert_reset_idle_R9: assert property (@(posedge clk_i)
    !rst_ni |=> (drv_dom_o == '0 && rx_loc_o && rx_exp_o));
endmodule

// File: tb/tb_rep_logic_unit.sv
module tb_rep_logic_unit;
  localparam int REL = 6;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tx_loc_i = 1'b1, tx_exp_i = 1'b1;
  logic [1:0] bus_en_ni = 2'b00, rx_cmp_i = 2'b11;
  logic [1:0] drv_dom_o;
  logic       rx_loc_o, rx_exp_o;

  int checks = 0, errors = 0, cycles = 0;

  always #4 clk = ~clk;

  rep_logic_unit #(.NSEG(2), .SYNC_STAGES(2), .RELEASE_CYC(REL)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .tx_loc_i(tx_loc_i), .tx_exp_i(tx_exp_i),
    .bus_en_ni(bus_en_ni), .rx_cmp_i(rx_cmp_i),
    .drv_dom_o(drv_dom_o), .rx_loc_o(rx_loc_o), .rx_exp_o(rx_exp_o)
  );

  // behavioural reference: comparator delay line, per-segment hold timers
  logic [1:0] cmp_hist[$];
  int         hold_left[2];
  bit         m_drv[2];
  bit         m_rxl, m_rxe;

  task automatic model_reset();
    cmp_hist = {2'b11, 2'b11};
    hold_left[0] = 0; hold_left[1] = 0;
    m_drv[0] = 0; m_drv[1] = 0;
    m_rxl = 1; m_rxe = 1;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_ni) model_reset();
    else begin
      logic [1:0] seen;
      bit heard[2];
      bit nd[2];
      bit txd;
      seen = cmp_hist.pop_front();
      cmp_hist.push_back(rx_cmp_i);
      txd = !tx_loc_i || !tx_exp_i;
      for (int k = 0; k < 2; k++)
        heard[k] = !bus_en_ni[k] && !seen[k] && !(m_drv[k] || hold_left[k] > 0);
      for (int k = 0; k < 2; k++)
        nd[k] = !bus_en_ni[k] && (txd || heard[1-k]);
      m_rxl = !(txd || heard[0] || heard[1]);
      m_rxe = !(!tx_loc_i || heard[0] || heard[1]);
      for (int k = 0; k < 2; k++) begin
        if (m_drv[k]) hold_left[k] = REL;
        else if (hold_left[k] > 0) hold_left[k]--;
        m_drv[k] = nd[k];
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_ni) begin
      chk("R2/R3/R4/R7/R8 drv_dom_o vs model", {30'd0, drv_dom_o}, {30'd0, m_drv[1], m_drv[0]});
      chk("R4/R5/R6/R7 rx_loc_o vs model", {31'd0, rx_loc_o}, {31'd0, m_rxl});
      chk("R4/R5/R6 rx_exp_o vs model", {31'd0, rx_exp_o}, {31'd0, m_rxe});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle();
    tx_loc_i = 1; tx_exp_i = 1; rx_cmp_i = 2'b11; bus_en_ni = 2'b00;
    tick(REL + 6);
  endtask

  initial begin
    tick(2);
    chk("R9 drv in reset", {30'd0, drv_dom_o}, 32'd0);
    chk("R9 rx_loc in reset", {31'd0, rx_loc_o}, 32'd1);
    chk("R9 rx_exp in reset", {31'd0, rx_exp_o}, 32'd1);
    rst_ni = 1;
    tick(2);
    chk("R9 drv after reset", {30'd0, drv_dom_o}, 32'd0);
    chk("R1 idle rx_loc high", {31'd0, rx_loc_o}, 32'd1);

    // R3 / R5: local transmit
    tx_loc_i = 0; tick(1);
    chk("R3 local tx drives both", {30'd0, drv_dom_o}, 32'd3);
    chk("R5 local tx to rx_loc", {31'd0, rx_loc_o}, 32'd0);
    chk("R5 local tx to rx_exp", {31'd0, rx_exp_o}, 32'd0);
    idle();

    // R6: expansion transmit
    tx_exp_i = 0; tick(1);
    chk("R3 exp tx drives both", {30'd0, drv_dom_o}, 32'd3);
    chk("R6 exp tx to rx_loc", {31'd0, rx_loc_o}, 32'd0);
    chk("R6 exp tx leaves rx_exp", {31'd0, rx_exp_o}, 32'd1);
    idle();

    // R2: segment 0 disabled
    bus_en_ni = 2'b01; tx_loc_i = 0; tick(1);
    chk("R2 disabled seg not driven", {30'd0, drv_dom_o}, 32'd2);
    idle();

    // R5: both disabled, local tx still echoes
    bus_en_ni = 2'b11; tx_loc_i = 0; tick(1);
    chk("R5 no drive when disabled", {30'd0, drv_dom_o}, 32'd0);
    chk("R5 rx_exp independent of enables", {31'd0, rx_exp_o}, 32'd0);
    idle();

    // R2: comparator on disabled segment ignored
    bus_en_ni = 2'b01; rx_cmp_i = 2'b10; tick(4);
    chk("R2 disabled cmp no drive", {30'd0, drv_dom_o}, 32'd0);
    chk("R2 disabled cmp rx_loc", {31'd0, rx_loc_o}, 32'd1);
    idle();

    // R4 + R7 + R8: cross forwarding with echo
    rx_cmp_i = 2'b10; tick(2);
    chk("R4 not yet through sync", {30'd0, drv_dom_o}, 32'd0);
    tick(1);
    chk("R4 seg0 forwarded to seg1", {30'd0, drv_dom_o}, 32'd2);
    chk("R4 rx_loc low", {31'd0, rx_loc_o}, 32'd0);
    chk("R4 rx_exp low", {31'd0, rx_exp_o}, 32'd0);
    rx_cmp_i = 2'b00; tick(4);
    chk("R7 echo on seg1 masked", {30'd0, drv_dom_o}, 32'd2);
    rx_cmp_i = 2'b01; tick(3);
    chk("R4 release reaches seg1", {30'd0, drv_dom_o}, 32'd0);
    tick(1); rx_cmp_i = 2'b11;
    for (int i = 0; i < REL + 4; i++) begin
      tick(1);
      chk("R8 no lock-up during release", {31'd0, drv_dom_o[0]}, 32'd0);
    end
    idle();

    // R8: genuine dominant after the window is forwarded
    rx_cmp_i = 2'b10; tick(5);
    rx_cmp_i = 2'b01; tick(3 + REL + 4);
    chk("R8 mask clears", {31'd0, drv_dom_o[0]}, 32'd1);
    idle();

    // mixed stimulus, checked against the model every clock
    for (int i = 0; i < 3000; i++) begin
      tx_loc_i  = ($urandom_range(0, 9) != 0);
      tx_exp_i  = ($urandom_range(0, 9) != 0);
      rx_cmp_i  = {($urandom_range(0, 5) != 0), ($urandom_range(0, 5) != 0)};
      if ($urandom_range(0, 19) == 0) bus_en_ni = 2'($urandom_range(0, 3));
      tick($urandom_range(1, 4));
    end
    idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule